// File: doc/BRIEF.md
# Serial Adapter Host Register Interface

This block is the processor-side front end of an asynchronous serial adapter. A host reaches it through a chip select, separate read and write strobes, one address bit and an 8-bit data bus. With the address bit low, a write loads the control word and a read returns the status byte. With the address bit high, a write fills the transmit holding register and a read returns the receive holding register. The bit-level shifters sit outside this block and attach through two byte streams.

The control word is decoded into settings for the serial side: a bit-clock divide ratio, one of eight character formats, the request-to-send level, a break request, and two interrupt enables. One divider code does not change the divider. Instead it performs a transmitter master reset. The status byte reports the holding-register states, the two modem inputs, the error flags captured with the received character, and the interrupt state. Interrupt causes are held in flags that drive a registered, active-high `irq` until the host touches the register that caused them.

The transmit stream (`tx_valid`/`tx_ready`/`tx_data`) offers the holding register to the shifter. `tx_valid` stays high with stable data until `tx_ready` is seen high at a clock edge. The receive stream (`rx_valid`/`rx_ready`/`rx_data`) accepts a character only while the receive holding register is empty. The shifter must hold `rx_valid` and its data until it sees `rx_ready` high at a clock edge. This is the back-pressure rule on the receive side.

Top module: `sa_host_regs`

## Requirements
- R1: After reset, `irq` is 0, `rdata` is 0, `baud_div` is 1, `rts` and `tx_break` are 0, `tx_valid` is 0, `rx_ready` is 1, and the status byte reads 0x02 when the modem inputs are low.
- R2: A control write whose bits [1:0] are 00, 01 or 10 sets `baud_div` to 1, 16 or 64 respectively, from the cycle after the write.
- R3: A control write with bits [1:0] = 11 is a master reset. It drives `rts` and `tx_break` to 0 and pulses `xcvr_reset` high for exactly the cycle after the write. The divider, format, interrupt enables and stored data are left unchanged.
- R4: Control bits [4:2] = n select the character format. `word_eight` is 1 for n of 4 or more. `parity_en` is 0 only for n = 4 and n = 5. `parity_odd` is 1 for n = 1, 3 and 7. `two_stop` is 1 for n = 0, 1 and 4.
- R5: Control bits [6:5] set the transmit controls. 00 gives `rts`=0 with the transmit interrupt off. 01 gives `rts`=0 with the transmit interrupt on. 10 gives `rts`=1 with the transmit interrupt off. 11 gives `rts`=0 with the transmit interrupt off and `tx_break`=1. Bit 7 enables the receive interrupt.
- R6: The status byte has the following layout. Bit 0 is receive register full. Bit 1 is transmit register empty. Bit 2 is `carrier_det`. Bit 3 is `clear_to_send`. Bit 4 is the framing error captured with the held character. Bit 5 is `rx_overrun`. Bit 6 is the parity error captured with the held character. Bit 7 is `irq`.
- R7: A transmit-data write raises `tx_valid` in the next cycle. `tx_data` shows the written byte, with bit 7 forced to 0 when a 7-bit format is selected. The value stays until accepted. A second write before acceptance replaces the byte. The register empties in the cycle after a `tx_valid`/`tx_ready` handshake.
- R8: `rx_ready` is high exactly while the receive register is empty. An accepted character is stored with bit 7 forced to 0 in 7-bit formats, together with its error flags. A receive-data read returns it and empties the register and clears both flags.
- R9: A receive handshake while the receive interrupt is enabled raises a receive cause and a status cause, and `irq` is high in the next cycle. A receive-data read clears only the receive cause.
- R10: A transmit handshake while the transmit interrupt is enabled raises a transmit cause and a status cause. A transmit-data write clears the transmit cause.
- R11: A status read clears the status cause. `irq` stays high until every cause is clear.
- R12: With both interrupt enables off, handshakes raise no cause and `irq` stays 0.
- R13: `rdata` is registered. It changes only in the cycle after a read strobe and holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, sampled with `cs` |
| wr | input | 1 | Write strobe, sampled with `cs` |
| addr | input | 1 | 0: control/status, 1: transmit/receive data |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered host read data |
| irq | output | 1 | Interrupt request, active high |
| tx_valid | output | 1 | Transmit holding register full |
| tx_ready | input | 1 | Transmit shifter takes the byte |
| tx_data | output | 8 | Byte offered to the transmit shifter |
| rx_valid | input | 1 | Receive shifter offers a character |
| rx_ready | output | 1 | Receive holding register empty |
| rx_data | input | 8 | Character from the receive shifter |
| rx_frame_err | input | 1 | Framing error, qualified by `rx_valid` |
| rx_parity_err | input | 1 | Parity error, qualified by `rx_valid` |
| rx_overrun | input | 1 | Overrun flag from the receiver, shown live in status |
| carrier_det | input | 1 | Carrier detect level, shown in status |
| clear_to_send | input | 1 | Clear-to-send level, shown in status |
| baud_div | output | 7 | Bit-clock divide ratio: 1, 16 or 64 |
| word_eight | output | 1 | 1: eight data bits, 0: seven |
| parity_en | output | 1 | Parity bit present |
| parity_odd | output | 1 | Odd parity when parity is present |
| two_stop | output | 1 | Two stop bits |
| rts | output | 1 | Request-to-send, active high |
| tx_break | output | 1 | Hold the transmit line low |
| xcvr_reset | output | 1 | One-cycle transmitter master-reset pulse |

## Verification
The hardest state to reach is two interrupt causes held at once, with `irq` falling only when the second one is cleared. The stimulus builds this by completing a handshake and then touching only one of the two registers involved. For example, it reads received data before reading status, or writes new transmit data while the status cause is still pending. It checks `irq` after each single access. Receive back-pressure is reached by holding `rx_valid` high with a new character while the register is full. The check then confirms the held character survives and the waiting one is taken in the cycle after the data read.

// File: rtl/sa_pkg.sv
package sa_pkg;

  localparam int HOST_W = 8;

  typedef enum logic [1:0] {
    DIV_ONE  = 2'b00,
    DIV_MID  = 2'b01,
    DIV_HIGH = 2'b10,
    DIV_MRST = 2'b11
  } sa_div_e;

  typedef enum logic [1:0] {
    TXC_QUIET = 2'b00,
    TXC_TIRQ  = 2'b01,
    TXC_RTS   = 2'b10,
    TXC_BREAK = 2'b11
  } sa_txc_e;

  typedef struct packed {
    logic eight;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } sa_frame_t;

  localparam int N_CAUSE  = 2;
  localparam int CAUSE_RX = 0;
  localparam int CAUSE_TX = 1;

  // Character format selector to frame settings.
  function automatic sa_frame_t frame_of(input logic [2:0] sel);
    sa_frame_t f;
    f.eight    = sel[2];
    f.par_en   = !(sel[2] && !sel[1]);
    f.par_odd  = f.par_en && sel[0];
    f.two_stop = (sel[2:1] == 2'b00) || (sel == 3'd4);
    return f;
  endfunction

  // Clear the top bit when only seven data bits are carried.
  function automatic logic [HOST_W-1:0] trim7(input logic [HOST_W-1:0] d,
                                              input logic seven);
    return seven ? {1'b0, d[HOST_W-2:0]} : d;
  endfunction

endpackage

// File: rtl/sa_ctrl_decode.sv
module sa_ctrl_decode
  import sa_pkg::*;
#(
  parameter int DIV_MID_RATIO = 16,
  parameter int DIV_HI_RATIO  = 64,
  parameter int DIV_W         = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [HOST_W-1:0] wd,
  output logic [DIV_W-1:0]  baud_div,
  output sa_frame_t         frame,
  output logic              rts,
  output logic              tx_break,
  output logic              tx_ie,
  output logic              rx_ie,
  output logic              xcvr_reset
);

  sa_div_e    div_q;
  logic [2:0] fmt_q;
  logic       rts_q, brk_q, tie_q, rie_q, mrst_q;
  sa_div_e    div_sel;
  sa_txc_e    txc_sel;

  assign div_sel = sa_div_e'(wd[1:0]);
  assign txc_sel = sa_txc_e'(wd[6:5]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= DIV_ONE;
      fmt_q  <= '0;
      rts_q  <= 1'b0;
      brk_q  <= 1'b0;
      tie_q  <= 1'b0;
      rie_q  <= 1'b0;
      mrst_q <= 1'b0;
    end else begin
      mrst_q <= 1'b0;
      if (we) begin
        if (div_sel == DIV_MRST) begin
          rts_q  <= 1'b0;
          brk_q  <= 1'b0;
          mrst_q <= 1'b1;
        end else begin
          div_q <= div_sel;
          fmt_q <= wd[4:2];
          rts_q <= (txc_sel == TXC_RTS);
          tie_q <= (txc_sel == TXC_TIRQ);
          brk_q <= (txc_sel == TXC_BREAK);
          rie_q <= wd[7];
        end
      end
    end
  end

  always_comb begin
    case (div_q)
      DIV_MID:  baud_div = DIV_W'(DIV_MID_RATIO);
      DIV_HIGH: baud_div = DIV_W'(DIV_HI_RATIO);
      default:  baud_div = DIV_W'(1);
    endcase
  end

  assign frame      = frame_of(fmt_q);
  assign rts        = rts_q;
  assign tx_break   = brk_q;
  assign tx_ie      = tie_q;
  assign rx_ie      = rie_q;
  assign xcvr_reset = mrst_q;

endmodule

// File: rtl/sa_irq_track.sv
module sa_irq_track #(
  parameter int NC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NC-1:0] raise,
  input  logic [NC-1:0] clr,
  input  logic          stat_clr,
  output logic          irq
);

  logic [NC-1:0] cause_q, cause_d;
  logic          stat_q, stat_d;
  logic          irq_q;

  // A new event wins over a clear in the same cycle.
  assign cause_d = raise | (cause_q & ~clr);
  assign stat_d  = (|raise) | (stat_q & ~stat_clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      stat_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      cause_q <= cause_d;
      stat_q  <= stat_d;
      irq_q   <= (|cause_d) | stat_d;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/sa_data_path.sv
module sa_data_path
  import sa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seven,
  // transmit side
  input  logic              tx_we,
  input  logic [HOST_W-1:0] wd,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [HOST_W-1:0] tx_data,
  output logic              tx_take,
  // receive side
  input  logic              rx_valid,
  input  logic [HOST_W-1:0] rx_data,
  input  logic              rx_fe,
  input  logic              rx_pe,
  input  logic              rx_re,
  output logic              rx_ready,
  output logic              rx_take,
  output logic              rx_full,
  output logic [HOST_W-1:0] rx_word,
  output logic              fe_held,
  output logic              pe_held
);

  logic [HOST_W-1:0] tx_hold_q, rx_hold_q;
  logic              tx_full_q, rx_full_q, fe_q, pe_q;

  assign tx_take = tx_full_q && tx_ready;
  assign rx_take = rx_valid && !rx_full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_hold_q <= '0;
      tx_full_q <= 1'b0;
    end else if (tx_we) begin
      tx_hold_q <= wd;
      tx_full_q <= 1'b1;
    end else if (tx_take) begin
      tx_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_hold_q <= '0;
      rx_full_q <= 1'b0;
      fe_q      <= 1'b0;
      pe_q      <= 1'b0;
    end else if (rx_take) begin
      rx_hold_q <= trim7(rx_data, seven);
      rx_full_q <= 1'b1;
      fe_q      <= rx_fe;
      pe_q      <= rx_pe;
    end else if (rx_re) begin
      rx_full_q <= 1'b0;
      fe_q      <= 1'b0;
      pe_q      <= 1'b0;
    end
  end

  assign tx_valid = tx_full_q;
  assign tx_data  = trim7(tx_hold_q, seven);
  assign rx_ready = !rx_full_q;
  assign rx_full  = rx_full_q;
  assign rx_word  = rx_hold_q;
  assign fe_held  = fe_q;
  assign pe_held  = pe_q;

endmodule

// File: rtl/sa_host_regs.sv
module sa_host_regs
  import sa_pkg::*;
#(
  parameter  int DIV_MID_RATIO = 16,
  parameter  int DIV_HI_RATIO  = 64,
  localparam int DIV_W         = $clog2(DIV_HI_RATIO + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic              addr,
  input  logic [HOST_W-1:0] wdata,
  output logic [HOST_W-1:0] rdata,
  output logic              irq,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [HOST_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [HOST_W-1:0] rx_data,
  input  logic              rx_frame_err,
  input  logic              rx_parity_err,
  input  logic              rx_overrun,
  input  logic              carrier_det,
  input  logic              clear_to_send,
  output logic [DIV_W-1:0]  baud_div,
  output logic              word_eight,
  output logic              parity_en,
  output logic              parity_odd,
  output logic              two_stop,
  output logic              rts,
  output logic              tx_break,
  output logic              xcvr_reset
);

  logic ctl_we, txd_we, st_re, rxd_re;
  assign ctl_we = cs && wr && !addr;
  assign txd_we = cs && wr &&  addr;
  assign st_re  = cs && rd && !addr;
  assign rxd_re = cs && rd &&  addr;

  sa_frame_t frame_w;
  logic      tx_ie_w, rx_ie_w;

  sa_ctrl_decode #(
    .DIV_MID_RATIO(DIV_MID_RATIO),
    .DIV_HI_RATIO (DIV_HI_RATIO),
    .DIV_W        (DIV_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (ctl_we),
    .wd        (wdata),
    .baud_div  (baud_div),
    .frame     (frame_w),
    .rts       (rts),
    .tx_break  (tx_break),
    .tx_ie     (tx_ie_w),
    .rx_ie     (rx_ie_w),
    .xcvr_reset(xcvr_reset)
  );

  logic              tx_take_w, rx_take_w, rx_full_w, fe_w, pe_w;
  logic [HOST_W-1:0] rx_word_w;

  sa_data_path u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .seven   (!frame_w.eight),
    .tx_we   (txd_we),
    .wd      (wdata),
    .tx_ready(tx_ready),
    .tx_valid(tx_valid),
    .tx_data (tx_data),
    .tx_take (tx_take_w),
    .rx_valid(rx_valid),
    .rx_data (rx_data),
    .rx_fe   (rx_frame_err),
    .rx_pe   (rx_parity_err),
    .rx_re   (rxd_re),
    .rx_ready(rx_ready),
    .rx_take (rx_take_w),
    .rx_full (rx_full_w),
    .rx_word (rx_word_w),
    .fe_held (fe_w),
    .pe_held (pe_w)
  );

  logic [N_CAUSE-1:0] raise_w, clr_w;
  assign raise_w[CAUSE_RX] = rx_take_w && rx_ie_w;
  assign raise_w[CAUSE_TX] = tx_take_w && tx_ie_w && !txd_we;
  assign clr_w[CAUSE_RX]   = rxd_re;
  assign clr_w[CAUSE_TX]   = txd_we;

  sa_irq_track #(.NC(N_CAUSE)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .raise   (raise_w),
    .clr     (clr_w),
    .stat_clr(st_re),
    .irq     (irq)
  );

  logic [HOST_W-1:0] status_w;
  assign status_w = {irq, pe_w, rx_overrun, fe_w,
                     clear_to_send, carrier_det, !tx_valid, rx_full_w};

  logic [HOST_W-1:0] rdata_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (st_re)  rdata_q <= status_w;
    else if (rxd_re) rdata_q <= rx_word_w;
  end
  assign rdata = rdata_q;

  assign word_eight = frame_w.eight;
  assign parity_en  = frame_w.par_en;
  assign parity_odd = frame_w.par_odd;
  assign two_stop   = frame_w.two_stop;

endmodule

// File: rtl/sa_host_regs_chk.sv
module sa_host_regs_chk #(
  parameter int DIV_MID_RATIO = 16,
  parameter int DIV_HI_RATIO  = 64,
  parameter int DIV_W         = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs,
  input logic             rd,
  input logic             wr,
  input logic             addr,
  input logic [7:0]       wdata,
  input logic [7:0]       rdata,
  input logic             irq,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic [DIV_W-1:0] baud_div,
  input logic             rts,
  input logic             tx_break,
  input logic             xcvr_reset,
  input logic             rx_ie
);

  assert_div_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_div == DIV_W'(1)) || (baud_div == DIV_W'(DIV_MID_RATIO)) ||
    (baud_div == DIV_W'(DIV_HI_RATIO)));

  assert_mrst_effect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && !addr && wdata[1:0] == 2'b11) |=> (xcvr_reset && !rts && !tx_break));

  assert_mrst_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xcvr_reset |-> $past(cs && wr && !addr && wdata[1:0] == 2'b11));

  assert_rts_brk_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rts && tx_break));

  assert_tx_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr) |=> tx_valid);

  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !(cs && wr)) |=> (tx_valid && $stable(tx_data)));

  assert_rx_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> !rx_ready);

  assert_rx_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_ie) |=> irq);

  assert_irq_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((rx_valid && rx_ready) || (tx_valid && tx_ready)));

  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cs && rd) |-> $stable(rdata));

endmodule

bind sa_host_regs sa_host_regs_chk #(
  .DIV_MID_RATIO(DIV_MID_RATIO),
  .DIV_HI_RATIO (DIV_HI_RATIO),
  .DIV_W        (DIV_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs        (cs),
  .rd        (rd),
  .wr        (wr),
  .addr      (addr),
  .wdata     (wdata),
  .rdata     (rdata),
  .irq       (irq),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .baud_div  (baud_div),
  .rts       (rts),
  .tx_break  (tx_break),
  .xcvr_reset(xcvr_reset),
  .rx_ie     (rx_ie_w)
);

// File: tb/sa_host_regs_test.sv
`timescale 1ns/1ps
module sa_host_regs_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, tx_valid, rx_ready;
  logic       tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_frame_err = 1'b0, rx_parity_err = 1'b0, rx_overrun = 1'b0;
  logic       carrier_det = 1'b0, clear_to_send = 1'b0;
  logic [6:0] baud_div;
  logic       word_eight, parity_en, parity_odd, two_stop;
  logic       rts, tx_break, xcvr_reset;

  always #4 clk = ~clk;  // 125 MHz

  sa_host_regs uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err),
    .rx_overrun(rx_overrun), .carrier_det(carrier_det),
    .clear_to_send(clear_to_send), .baud_div(baud_div),
    .word_eight(word_eight), .parity_en(parity_en), .parity_odd(parity_odd),
    .two_stop(two_stop), .rts(rts), .tx_break(tx_break),
    .xcvr_reset(xcvr_reset)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic a, input logic [7:0] d);
    @(negedge clk); cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); cs = 1'b0; wr = 1'b0;
  endtask

  // Driver: queue the expected value, then strobe the read.
  task automatic host_read(input logic a, input logic [7:0] exp, input string req);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    cs = 1'b1; rd = 1'b1; addr = a;
    @(negedge clk); cs = 1'b0; rd = 1'b0;
  endtask

  task automatic tx_pulse();
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic rx_offer(input logic [7:0] d, input logic fe, input logic pe);
    @(negedge clk); rx_valid = 1'b1; rx_data = d; rx_frame_err = fe; rx_parity_err = pe;
    @(negedge clk); rx_valid = 1'b0; rx_frame_err = 1'b0; rx_parity_err = 1'b0;
  endtask

  // Monitor: compare read data one cycle after each read strobe.
  always @(posedge clk) rd_seen <= cs && rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R13: unexpected read result %02h expected none", rdata);
      end else begin
        check8(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check8("R1 irq", {7'd0, irq}, 8'h00);
    check8("R1 rdata", rdata, 8'h00);
    check8("R1 baud_div", {1'b0, baud_div}, 8'd1);
    check8("R1 rts/brk/txv/rxr", {4'd0, rts, tx_break, tx_valid, rx_ready}, 8'h01);
    host_read(1'b0, 8'h02, "R1 status");

    // R6 modem and overrun bits
    carrier_det = 1'b1; clear_to_send = 1'b1; rx_overrun = 1'b1;
    host_read(1'b0, 8'h2E, "R6 status modem");
    carrier_det = 1'b0; clear_to_send = 1'b0; rx_overrun = 1'b0;

    // R2 dividers
    host_write(1'b0, 8'h01); check8("R2 div16", {1'b0, baud_div}, 8'd16);
    host_write(1'b0, 8'h02); check8("R2 div64", {1'b0, baud_div}, 8'd64);
    host_write(1'b0, 8'h00); check8("R2 div1",  {1'b0, baud_div}, 8'd1);

    // R4 formats
    for (int n = 0; n < 8; n++) begin
      logic e8, pen, podd, ts;
      e8   = (n >= 4);
      pen  = !(n == 4 || n == 5);
      podd = (n == 1 || n == 3 || n == 7);
      ts   = (n == 0 || n == 1 || n == 4);
      host_write(1'b0, 8'((n << 2) | 1));
      check8($sformatf("R4 format %0d", n),
             {4'd0, word_eight, parity_en, parity_odd, two_stop},
             {4'd0, e8, pen, podd, ts});
    end

    // R5 transmit controls
    host_write(1'b0, 8'h40); check8("R5 rts on",  {6'd0, rts, tx_break}, 8'h02);
    host_write(1'b0, 8'h60); check8("R5 break",   {6'd0, rts, tx_break}, 8'h01);
    host_write(1'b0, 8'h20); check8("R5 tie only", {6'd0, rts, tx_break}, 8'h00);

    // R3 master reset
    host_write(1'b0, 8'h45);
    host_write(1'b0, 8'h03);
    check8("R3 pulse/rts/brk", {5'd0, xcvr_reset, rts, tx_break}, 8'h04);
    check8("R3 div kept", {1'b0, baud_div}, 8'd16);
    check8("R3 format kept", {4'd0, word_eight, parity_en, parity_odd, two_stop}, 8'h07);
    @(negedge clk);
    check8("R3 single pulse", {7'd0, xcvr_reset}, 8'h00);
    host_write(1'b0, 8'h60);
    host_write(1'b0, 8'h03);
    check8("R3 break cleared", {7'd0, tx_break}, 8'h00);

    // R7 transmit holding
    host_write(1'b0, 8'h14);
    host_write(1'b1, 8'hA5);
    check8("R7 load", {tx_valid, 7'd0}, 8'h80);
    check8("R7 data", tx_data, 8'hA5);
    host_read(1'b0, 8'h00, "R7 status full");
    host_write(1'b1, 8'h3C);
    check8("R7 overwrite", tx_data, 8'h3C);
    repeat (2) @(negedge clk);
    check8("R7 held", {tx_valid, 7'd0}, 8'h80);
    tx_pulse();
    check8("R7 drained", {7'd0, tx_valid}, 8'h00);
    host_read(1'b0, 8'h02, "R7 status empty");
    host_write(1'b0, 8'h08);
    host_write(1'b1, 8'hFF);
    check8("R7 seven-bit", tx_data, 8'h7F);
    host_write(1'b0, 8'h14);
    tx_pulse();
    check8("R12 no tx irq", {7'd0, irq}, 8'h00);

    // R10 transmit interrupt
    host_write(1'b0, 8'h34);
    host_write(1'b1, 8'h11);
    tx_pulse();
    check8("R10 raised", {7'd0, irq}, 8'h01);
    host_read(1'b0, 8'h82, "R10 status irq");
    check8("R11 tx cause holds", {7'd0, irq}, 8'h01);
    host_write(1'b1, 8'h22);
    check8("R10 write clears", {7'd0, irq}, 8'h00);
    tx_pulse();
    check8("R10 raised again", {7'd0, irq}, 8'h01);
    host_write(1'b1, 8'h33);
    check8("R11 status cause holds", {7'd0, irq}, 8'h01);
    host_read(1'b0, 8'h80, "R11 status full irq");
    check8("R11 all clear", {7'd0, irq}, 8'h00);
    host_write(1'b0, 8'h14);
    tx_pulse();
    check8("R12 tie off", {tx_valid, 6'd0, irq}, 8'h00);

    // R9 receive interrupt with framing error
    host_write(1'b0, 8'h94);
    rx_offer(8'hC3, 1'b1, 1'b0);
    check8("R9 taken", {rx_ready, 6'd0, irq}, 8'h01);
    host_read(1'b0, 8'h93, "R9 status");
    check8("R9 rx cause holds", {7'd0, irq}, 8'h01);
    host_read(1'b1, 8'hC3, "R8 data");
    check8("R9 read clears", {rx_ready, 6'd0, irq}, 8'h80);
    host_read(1'b0, 8'h02, "R8 flags cleared");

    // R11 data read first, status cause survives
    rx_offer(8'h81, 1'b0, 1'b0);
    host_read(1'b1, 8'h81, "R11 data");
    check8("R11 status pending", {7'd0, irq}, 8'h01);
    host_read(1'b0, 8'h82, "R11 status");
    check8("R11 irq low", {7'd0, irq}, 8'h00);

    // R8 back-pressure, interrupts off
    host_write(1'b0, 8'h14);
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h5A; rx_parity_err = 1'b1;
    @(negedge clk); rx_data = 8'h66; rx_parity_err = 1'b0;
    repeat (3) @(negedge clk);
    check8("R8 full stalls", {rx_ready, 6'd0, irq}, 8'h00);
    host_read(1'b0, 8'h43, "R8 status parity");
    host_read(1'b1, 8'h5A, "R8 held word");
    @(negedge clk); rx_valid = 1'b0;
    check8("R8 next taken", {7'd0, rx_ready}, 8'h00);
    host_read(1'b1, 8'h66, "R8 second word");
    check8("R12 rx irq off", {7'd0, irq}, 8'h00);

    // R8 seven-bit capture
    host_write(1'b0, 8'h08);
    rx_offer(8'hF0, 1'b0, 1'b0);
    host_read(1'b1, 8'h70, "R8 seven-bit");

    // R13 hold between reads
    repeat (3) @(negedge clk);
    check8("R13 hold", rdata, 8'h70);
    host_write(1'b0, 8'h14);
    host_write(1'b1, 8'h99);
    check8("R13 writes ignored", rdata, 8'h70);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule